// File: doc/BRIEF.md
# Double-Buffered PLL Control Register Bank

This block is the byte-wide configuration store that sits behind a serial-port front end and drives the digital control outputs of a phase-locked loop. Each cycle the front end presents an address and either a data byte with a write strobe or a read strobe. Reads return data one cycle later on a registered output.

The four registers from 0x0A to 0x0D are buffered. A write to one of them changes only its pending (shadow) copy. The active copy, which drives the PLL outputs, takes the pending values only when an update command is written to 0x05. Three registers act as soon as they are written:
- 0x00 holds the serial-port configuration and the soft-reset command.
- 0x04 chooses whether reads of buffered registers return the pending copy or the active copy.
- 0x05 holds the update command.

Per-field enable bits choose between the automatic values on the input pins and the values held in the registers. This applies to the charge-pump current, the charge-pump mode and the antibacklash period.

Top module: `pllcfg_regbank`

## Requirements
- R1: After reset, `rdata` is 0x00 and `lsb_first`, `fb_neg_edge`, `ref_neg_edge` and `vco_mid` are 0. `cp_current`, `cp_mode` and `abl_period` follow the `auto_*` inputs.
- R2: A read of 0x00 returns the byte {0, L, 0, 1, 0, L, 0, 1} (bits 7 down to 0), where L is the stored bit-order flag. Written values of bits 7, 4 and 3..0 have no effect on the stored state.
- R3: A write to 0x00 with bit 5 clear sets `lsb_first` to written bit 6 from the next cycle on.
- R4: A write to 0x00 with bit 5 set returns every register to its default from the next cycle on. This covers the pending and active copies of the buffered registers (0x0A=0x80, 0x0B=0x30, 0x0C=0x00, 0x0D=0x00), the bit-order flag and the readback select. Bit 5 always reads 0.
- R5: A write to 0x0A..0x0D changes only the pending copy. The PLL control outputs do not change until an update command.
- R6: A write to 0x05 with bit 0 set copies every pending register into the active copy, effective the next cycle. 0x05 always reads 0x00.
- R7: 0x04 bit 0 selects the readback source for 0x0A..0x0D: 0 returns the active copy, 1 returns the pending copy. 0x04 reads back as {7'b0, select}.
- R8: `cp_current` equals active 0x0A when active 0x0B bit 7 is 1. Otherwise it equals `auto_cp_current`.
- R9: `cp_mode` equals active 0x0B bits 5:4 when active 0x0B bit 3 is 1. Otherwise it equals `auto_cp_mode`. The codes are 00 tristate, 01 pump up, 10 pump down and 11 normal.
- R10: `abl_period` equals active 0x0D bits 7:6 when active 0x0B bit 6 is 1. Otherwise it equals `auto_abl_period`.
- R11: `fb_neg_edge`, `ref_neg_edge` and `vco_mid` equal active 0x0B bits 2, 1 and 0 respectively.
- R12: Unused register bits (all of 0x0C and 0x0D bits 5:0) store nothing and read 0. Any unmapped address reads 0x00.
- R13: `rdata` loads the addressed byte on the clock edge where `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Register byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| rdata | output | 8 | Registered read data |
| auto_cp_current | input | 8 | Automatic charge-pump current code |
| auto_cp_mode | input | 2 | Automatic charge-pump mode |
| auto_abl_period | input | 2 | Automatic antibacklash period |
| lsb_first | output | 1 | Serial bit-order select for the front end |
| cp_current | output | 8 | Charge-pump current code in use |
| cp_mode | output | 2 | Charge-pump mode in use |
| abl_period | output | 2 | Antibacklash period in use |
| fb_neg_edge | output | 1 | Feedback input active on falling edge |
| ref_neg_edge | output | 1 | Reference input active on falling edge |
| vco_mid | output | 1 | Force VCO control to midscale |

## Verification
The hardest situation to reach from the ports is a pending copy and an active copy that differ in every override field at once. A visible mismatch only appears when the outputs, or a read with each readback setting, are sampled between a buffered write and the following update. The stimulus builds this state in two ways. Directed sequences write the override registers, read them back under both readback settings, and only then issue the update. A seeded random run then mixes buffered writes, readback-select flips, updates and occasional soft resets, so that the two copies drift apart over long stretches. A bench model compares every read and every output after every operation.

// File: rtl/pllcfg_pkg.sv
// Package: shared addresses, buffered-register layout and defaults for the
// PLL control register bank. Assumes byte-wide registers.
package pllcfg_pkg;
    localparam int          NBUF        = 4;
    localparam logic [7:0]  BUF_BASE    = 8'h0A;
    localparam logic [7:0]  ADDR_SPORT  = 8'h00;
    localparam logic [7:0]  ADDR_RBSEL  = 8'h04;
    localparam logic [7:0]  ADDR_UPDATE = 8'h05;
    localparam int          IDXW        = $clog2(NBUF);

    typedef logic [7:0] byte_t;

    // Writable-bit mask of buffered register i (offset from BUF_BASE)
    function automatic byte_t buf_mask(input int i);
        case (i)
            0:       return 8'hFF;
            1:       return 8'hFF;
            3:       return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    // Reset value of buffered register i
    function automatic byte_t buf_default(input int i);
        case (i)
            0:       return 8'h80;
            1:       return 8'h30;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/pllcfg_sport.sv
// Immediate-acting configuration: the bit-order flag, the readback select,
// and decode of the self-clearing soft-reset and update commands.
// Assumes one write per cycle; command outputs are single-cycle pulses.
module pllcfg_sport (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_sport,
    input  logic wr_rbsel,
    input  logic wr_update,
    input  logic wbit6,
    input  logic wbit5,
    input  logic wbit0,
    output logic lsb_first,
    output logic rb_shadow,
    output logic soft_rst,
    output logic update
);
    // Commands are pulses; nothing is stored, so they read back as 0
    assign soft_rst = wr_sport & wbit5;
    assign update   = wr_update & wbit0;

    // Bit-order flag and readback select, both cleared by either reset
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            lsb_first <= 1'b0;
            rb_shadow <= 1'b0;
        end else begin
            if (wr_sport)
                lsb_first <= wbit6;
            if (wr_rbsel)
                rb_shadow <= wbit0;
        end
    end
endmodule

// File: rtl/pllcfg_dbuf.sv
// Pending/active register pairs for the buffered registers. A write lands in
// the pending copy, masked to the writable bits. An update copies all pending
// registers to active. A soft reset beats an update and restores both copies.
module pllcfg_dbuf
    import pllcfg_pkg::*;
#(
    parameter int N  = NBUF,
    parameter int IW = IDXW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             update,
    input  logic             wr_hit,
    input  logic [IW-1:0]    widx,
    input  byte_t            wdata,
    output logic [N-1:0][7:0] shadow,
    output logic [N-1:0][7:0] active
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        localparam byte_t MASK = buf_mask(i);
        localparam byte_t DEF  = buf_default(i);

        // One pending/active pair: reset, masked write, then transfer
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                shadow[i] <= DEF;
                active[i] <= DEF;
            end else begin
                if (wr_hit && widx == IW'(i))
                    shadow[i] <= wdata & MASK;
                if (update)
                    active[i] <= shadow[i];
            end
        end
    end
endmodule

// File: rtl/pllcfg_ovr.sv
// Chooses, field by field, between the automatic inputs and the active
// register values. Purely combinational.
module pllcfg_ovr (
    input  logic [7:0] cur_reg,
    input  logic [7:0] ctl_reg,
    input  logic [1:0] abl_reg,
    input  logic [7:0] auto_cur,
    input  logic [1:0] auto_mode,
    input  logic [1:0] auto_abl,
    output logic [7:0] cp_current,
    output logic [1:0] cp_mode,
    output logic [1:0] abl_period,
    output logic       fb_neg_edge,
    output logic       ref_neg_edge,
    output logic       vco_mid
);
    // Enables: bit 7 current, bit 6 antibacklash, bit 3 mode
    always_comb begin
        cp_current   = ctl_reg[7] ? cur_reg      : auto_cur;
        abl_period   = ctl_reg[6] ? abl_reg      : auto_abl;
        cp_mode      = ctl_reg[3] ? ctl_reg[5:4] : auto_mode;
        fb_neg_edge  = ctl_reg[2];
        ref_neg_edge = ctl_reg[1];
        vco_mid      = ctl_reg[0];
    end
endmodule

// File: rtl/pllcfg_regbank.sv
// Top of the PLL control register bank. Decodes byte accesses from the serial
// front end, holds immediate and buffered registers, drives the PLL control
// outputs and returns registered read data one cycle after rd_en.
// Assumes wr_en and rd_en are never high in the same cycle.
module pllcfg_regbank
    import pllcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       wr_en,
    input  logic       rd_en,
    output logic [7:0] rdata,
    input  logic [7:0] auto_cp_current,
    input  logic [1:0] auto_cp_mode,
    input  logic [1:0] auto_abl_period,
    output logic       lsb_first,
    output logic [7:0] cp_current,
    output logic [1:0] cp_mode,
    output logic [1:0] abl_period,
    output logic       fb_neg_edge,
    output logic       ref_neg_edge,
    output logic       vco_mid
);
    logic               rb_shadow, soft_rst, update, buf_hit;
    logic [IDXW-1:0]    bidx;
    logic [7:0]         boff;
    logic [NBUF-1:0][7:0] shadow, active;
    byte_t              rd_byte;
    logic [3:0]         sport_nib;
    logic               unused_bits;

    // Offset into the buffered window and its hit flag
    assign boff    = addr - BUF_BASE;
    assign bidx    = boff[IDXW-1:0];
    assign buf_hit = (addr >= BUF_BASE) && (boff < 8'(NBUF));

    pllcfg_sport u_sport (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sport (wr_en && addr == ADDR_SPORT),
        .wr_rbsel (wr_en && addr == ADDR_RBSEL),
        .wr_update(wr_en && addr == ADDR_UPDATE),
        .wbit6    (wdata[6]),
        .wbit5    (wdata[5]),
        .wbit0    (wdata[0]),
        .lsb_first(lsb_first),
        .rb_shadow(rb_shadow),
        .soft_rst (soft_rst),
        .update   (update)
    );

    pllcfg_dbuf #(.N(NBUF), .IW(IDXW)) u_dbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .soft_rst(soft_rst),
        .update  (update),
        .wr_hit  (wr_en && buf_hit),
        .widx    (bidx),
        .wdata   (wdata),
        .shadow  (shadow),
        .active  (active)
    );

    pllcfg_ovr u_ovr (
        .cur_reg     (active[0]),
        .ctl_reg     (active[1]),
        .abl_reg     (active[3][7:6]),
        .auto_cur    (auto_cp_current),
        .auto_mode   (auto_cp_mode),
        .auto_abl    (auto_abl_period),
        .cp_current  (cp_current),
        .cp_mode     (cp_mode),
        .abl_period  (abl_period),
        .fb_neg_edge (fb_neg_edge),
        .ref_neg_edge(ref_neg_edge),
        .vco_mid     (vco_mid)
    );

    // Active bytes with no control function are only visible on readback
    assign unused_bits = ^{active[2], active[3][5:0]};

    // 0x00 upper nibble: forced 0, bit-order flag, self-clearing 0, forced 1
    assign sport_nib = {1'b0, lsb_first, 1'b0, 1'b1};

    // Read selection for the addressed byte
    always_comb begin
        if (addr == ADDR_SPORT)
            rd_byte = {sport_nib, sport_nib};
        else if (addr == ADDR_RBSEL)
            rd_byte = {7'b0, rb_shadow};
        else if (buf_hit)
            rd_byte = rb_shadow ? shadow[bidx] : active[bidx];
        else
            rd_byte = 8'h00;
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd_en)
            rdata <= rd_byte;
    end
endmodule

// File: rtl/pllcfg_regbank_chk.sv
// Checker for the PLL control register bank. Observes the top-level ports
// only and is attached to every instance by the bind below.
module pllcfg_regbank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] addr,
    input logic [7:0] wdata,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] rdata,
    input logic       lsb_first,
    input logic       fb_neg_edge,
    input logic       ref_neg_edge,
    input logic       vco_mid
);
    logic cmd_cycle;
    logic mapped;

    // Writes that may change the active copy
    assign cmd_cycle = wr_en && ((addr == 8'h05 && wdata[0]) || (addr == 8'h00 && wdata[5]));
    assign mapped    = (addr == 8'h00) || (addr == 8'h04) || (addr == 8'h05) ||
                       (addr >= 8'h0A && addr <= 8'h0D);

    assert_lsb_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h00 && !wdata[5]) |=> (lsb_first == $past(wdata[6])));

    assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h00 && wdata[5]) |=>
            (!lsb_first && !fb_neg_edge && !ref_neg_edge && !vco_mid));

    assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_cycle |=> ($stable(fb_neg_edge) && $stable(ref_neg_edge) && $stable(vco_mid)));

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |=> (rdata == 8'h00));

    assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind pllcfg_regbank pllcfg_regbank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .lsb_first(lsb_first),
    .fb_neg_edge(fb_neg_edge), .ref_neg_edge(ref_neg_edge), .vco_mid(vco_mid)
);

// File: tb/pllcfg_regbank_test.sv
// Self-checking bench: directed corner cases followed by seeded random
// operations, all compared with a bench-side model of the register bank.
module pllcfg_regbank_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0, wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata;
    logic [7:0] auto_cur = 8'h5A;
    logic [1:0] auto_mode = 2'b10, auto_abl = 2'b01;
    logic       lsb_first, fb_neg_edge, ref_neg_edge, vco_mid;
    logic [7:0] cp_current;
    logic [1:0] cp_mode, abl_period;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic [7:0] m_sh [4];
    logic [7:0] m_act[4];
    logic       m_lsb, m_sel;

    always #(CLK_PERIOD/2) clk = ~clk;

    pllcfg_regbank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .auto_cp_current(auto_cur),
        .auto_cp_mode(auto_mode), .auto_abl_period(auto_abl),
        .lsb_first(lsb_first), .cp_current(cp_current), .cp_mode(cp_mode),
        .abl_period(abl_period), .fb_neg_edge(fb_neg_edge),
        .ref_neg_edge(ref_neg_edge), .vco_mid(vco_mid)
    );

    function automatic logic [7:0] mask_of(input int i);
        return (i == 0 || i == 1) ? 8'hFF : (i == 3) ? 8'hC0 : 8'h00;
    endfunction

    function automatic logic [7:0] def_of(input int i);
        return (i == 0) ? 8'h80 : (i == 1) ? 8'h30 : 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_sh[i]  = def_of(i);
            m_act[i] = def_of(i);
        end
        m_lsb = 1'b0;
        m_sel = 1'b0;
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h00) begin
            if (d[5]) model_reset();
            else m_lsb = d[6];
        end else if (a == 8'h04) m_sel = d[0];
        else if (a == 8'h05) begin
            if (d[0]) for (int i = 0; i < 4; i++) m_act[i] = m_sh[i];
        end else if (a >= 8'h0A && a <= 8'h0D)
            m_sh[a - 8'h0A] = d & mask_of(int'(a - 8'h0A));
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'h00) return {1'b0, m_lsb, 2'b01, 1'b0, m_lsb, 2'b01};
        if (a == 8'h04) return {7'b0, m_sel};
        if (a >= 8'h0A && a <= 8'h0D)
            return m_sel ? m_sh[a - 8'h0A] : m_act[a - 8'h0A];
        return 8'h00;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string ctx);
        logic [7:0] e_cur;
        logic [1:0] e_mode, e_abl;
        e_cur  = m_act[1][7] ? m_act[0] : auto_cur;
        e_mode = m_act[1][3] ? m_act[1][5:4] : auto_mode;
        e_abl  = m_act[1][6] ? m_act[3][7:6] : auto_abl;
        check(cp_current == e_cur, {"R8 cp_current ", ctx}, cp_current, e_cur);
        check(cp_mode == e_mode, {"R9 cp_mode ", ctx}, {6'b0, cp_mode}, {6'b0, e_mode});
        check(abl_period == e_abl, {"R10 abl_period ", ctx}, {6'b0, abl_period}, {6'b0, e_abl});
        check({fb_neg_edge, ref_neg_edge, vco_mid} == m_act[1][2:0], {"R11 edge/vco ", ctx},
              {5'b0, fb_neg_edge, ref_neg_edge, vco_mid}, {5'b0, m_act[1][2:0]});
        check(lsb_first == m_lsb, {"R3 lsb_first ", ctx}, {7'b0, lsb_first}, {7'b0, m_lsb});
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string ctx);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        check_outputs(ctx);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [7:0] e;
        e = exp_read(a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(rdata == e, tag, rdata, e);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rdata == 8'h00, "R1 rdata after reset", rdata, 8'h00);
        check_outputs("R1 reset");

        // R2, R3: config byte forced/mirrored bits
        rd(8'h00, "R2 default config byte 0x11");
        wr(8'h00, 8'hDF, "R3 set lsb");
        rd(8'h00, "R2 config byte with lsb 0x55");
        wr(8'h00, 8'h90, "R3 clear lsb");
        rd(8'h00, "R2 forced bits after write");

        // R5, R7: pending vs active
        wr(8'h0A, 8'h33, "R5 pending current");
        wr(8'h0B, 8'h88, "R5 pending ctl");
        rd(8'h0A, "R7 active readback 0x0A");
        wr(8'h04, 8'h01, "R7 select pending");
        rd(8'h0A, "R7 pending readback 0x0A");
        rd(8'h04, "R7 select readback");
        // R6 update
        wr(8'h05, 8'h01, "R6 update");
        rd(8'h05, "R6 update reads zero");
        // R9 mode override codes
        wr(8'h0B, 8'h18, "R9 pending pump up");
        wr(8'h05, 8'h01, "R9 pump up");
        wr(8'h0B, 8'h28, "R9 pending pump down");
        wr(8'h05, 8'h01, "R9 pump down");
        // R10, R11
        wr(8'h0D, 8'hFF, "R10 pending abl");
        rd(8'h0D, "R12 0x0D low bits read zero");
        wr(8'h0B, 8'h47, "R11 pending edges");
        wr(8'h05, 8'h01, "R10 R11 update");
        // R12 unmapped
        wr(8'h0C, 8'hFF, "R12 write 0x0C");
        rd(8'h0C, "R12 0x0C reads zero");
        rd(8'h33, "R12 unmapped reads zero");
        // R13 hold
        rd(8'h0D, "R13 read before hold");
        held = rdata;
        @(negedge clk);
        @(negedge clk);
        check(rdata == held, "R13 rdata holds", rdata, held);
        // R4 soft reset clears both copies
        wr(8'h0A, 8'h11, "R4 pending before reset");
        wr(8'h00, 8'h60, "R4 soft reset");
        rd(8'h0A, "R4 active default after reset");
        wr(8'h04, 8'h01, "R4 select pending");
        rd(8'h0B, "R4 pending default after reset");

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a, d;
            int k;
            k = int'($urandom_range(0, 8));
            case (k)
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h05;
                3: a = 8'h0A;
                4: a = 8'h0B;
                5: a = 8'h0C;
                6: a = 8'h0D;
                default: a = 8'($urandom);
            endcase
            d = 8'($urandom);
            if (a == 8'h00 && $urandom_range(0, 7) != 0) d[5] = 1'b0;
            @(negedge clk);
            auto_cur  = 8'($urandom);
            auto_mode = 2'($urandom);
            auto_abl  = 2'($urandom);
            if ($urandom_range(0, 1) == 0) wr(a, d, "random write");
            else rd(a, "R7 R12 random read");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule